// File: doc/BRIEF.md
# Serial Packet Port Transmitter

This block feeds one input lane of a bit-serial packet switch. A client hands it a packet over a parallel request handshake: a destination address and a payload length in bytes. The payload bytes then follow on a second byte-wide handshake. The block turns the packet into a single-bit stream with two active-low strobes. The frame strobe falls on the first header bit and rises again on the final payload bit. The valid strobe is low only on slots that carry payload data.

Every packet has the same layout on the wire. First come the address bits, least significant bit first. Then come a fixed number of padding slots. Then come the payload bytes, each sent least significant bit first. Payload slots that carry no data are marked invalid. Such a slot appears when the client raises a gap request, or when the next byte has not yet arrived. After each packet the line spends one slot idle. After reset the block accepts no request for a fixed quiet period. A request with a zero length is accepted but sends nothing and raises an error pulse.

Top module: `pkt_ser_tx`

## Requirements
- R1: After reset is released, `req_ready_o` stays low and `frame_no` stays high for the first QUIET_CYC (15) rising edges. `req_ready_o` first goes high after edge 15, so the earliest frame can start after edge 16. During reset, `frame_no`=1, `valid_no`=1, `req_ready_o`=0 and `err_o`=0.
- R2: On the edge that accepts a request with a nonzero length, `frame_no` falls and the first header slot appears. The header takes ADDR_W (4) slots, carrying `req_addr_i` bit 0 first. Header slots have `valid_no`=1.
- R3: Exactly PAD_CYC (2) padding slots follow the header. In each, `frame_no`=0 and `valid_no`=1.
- R4: Payload bytes leave in the order they were accepted on the byte handshake. Each byte is sent bit 0 first, and each data slot has `valid_no`=0. With data always available and no gaps, the packet occupies exactly ADDR_W+PAD_CYC+8*len slots.
- R5: When `gap_i` is high before the edge that emits a payload slot, that slot is idle (`frame_no`=0, `valid_no`=1) and no payload bit is used up.
- R6: If no byte is on hand when a payload slot is due, that slot is idle in the same way. When bytes are always offered, no such slot occurs.
- R7: The final payload bit is sent with `frame_no`=1 and `valid_no`=0. This is the only slot with that combination, and it is the (8*len)-th data slot.
- R8: The slot after the final bit is idle (`frame_no`=1, `valid_no`=1). `req_ready_o` is low from the accept edge until that idle slot, and it is high during that idle slot.
- R9: A request with `req_len_i`=0 is accepted. `err_o` is high for exactly the one cycle after the accept edge, no frame starts, and `req_ready_o` stays high.
- R10: The block takes exactly `req_len_i` bytes per packet. `byte_ready_o` is low whenever no packet is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Packet request offered |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | ADDR_W | Destination address |
| req_len_i | input | LEN_W | Payload length in bytes |
| byte_valid_i | input | 1 | Payload byte offered |
| byte_ready_o | output | 1 | Payload byte can be taken |
| byte_data_i | input | BYTE_W | Payload byte |
| gap_i | input | 1 | Make the next payload slot idle |
| ser_o | output | 1 | Serial data bit |
| frame_no | output | 1 | Active-low frame strobe |
| valid_no | output | 1 | Active-low data qualifier |
| err_o | output | 1 | One-cycle zero-length reject pulse |

## Verification
A wrong slot counter shows up at once as a shifted header or a padding run of the wrong length. It is caught within the first ADDR_W+PAD_CYC slots of the frame. A lost or duplicated shifter bit, or a byte counter that is off by one, corrupts the next decoded byte or moves the frame rise. This appears at most 8 slots after the fault, or at the end of the packet. A quiet counter or ready path that is wrong appears as early acceptance, or as a missing idle slot between back-to-back packets.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAD,
    ST_PAY,
    ST_TAIL
  } tx_state_e;
endpackage

// File: rtl/pst_quiet.sv
module pst_quiet #(
  parameter int QUIET_CYC = 15,
  localparam int QW = $clog2(QUIET_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= QW'(QUIET_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pst_byte_feed.sv
module pst_byte_feed #(
  parameter int LEN_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              take_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  output logic              byte_ready_o,
  output logic              full_o,
  output logic [BYTE_W-1:0] data_o
);
  logic [LEN_W-1:0] fetch_left_q;
  logic             load;

  // ready depends on registers only, never on take_i
  assign byte_ready_o = (fetch_left_q != '0) && !full_o;
  assign load         = byte_ready_o && byte_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_left_q <= '0;
      full_o       <= 1'b0;
      data_o       <= '0;
    end else if (start_i) begin
      fetch_left_q <= len_i;
      full_o       <= 1'b0;
    end else begin
      if (load) begin
        fetch_left_q <= fetch_left_q - 1'b1;
        data_o       <= byte_data_i;
        full_o       <= 1'b1;
      end else if (take_i) begin
        full_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pst_pay_shift.sv
module pst_pay_shift #(
  parameter int LEN_W  = 8,
  parameter int BYTE_W = 8,
  localparam int BW = $clog2(BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              advance_i,
  input  logic              buf_full_i,
  input  logic [BYTE_W-1:0] buf_data_i,
  output logic              take_o,
  output logic              have_o,
  output logic              bit_o,
  output logic              last_o
);
  logic [BYTE_W-1:0] sh_q;
  logic [BW-1:0]     bits_left_q;
  logic [LEN_W-1:0]  bytes_left_q;
  logic              need;

  assign need   = (bits_left_q == '0);
  assign have_o = !need || buf_full_i;
  assign take_o = advance_i && need && buf_full_i;
  assign bit_o  = need ? buf_data_i[0] : sh_q[0];
  assign last_o = !need && (bits_left_q == BW'(1)) && (bytes_left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q         <= '0;
      bits_left_q  <= '0;
      bytes_left_q <= '0;
    end else if (start_i) begin
      bits_left_q  <= '0;
      bytes_left_q <= len_i;
    end else if (advance_i && have_o) begin
      if (need) begin
        sh_q         <= buf_data_i >> 1;
        bits_left_q  <= BW'(BYTE_W - 1);
        bytes_left_q <= bytes_left_q - 1'b1;
      end else begin
        sh_q        <= sh_q >> 1;
        bits_left_q <= bits_left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_ser_tx.sv
module pkt_ser_tx #(
  parameter int ADDR_W    = 4,
  parameter int LEN_W     = 8,
  parameter int BYTE_W    = 8,
  parameter int PAD_CYC   = 2,
  parameter int QUIET_CYC = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              gap_i,
  output logic              ser_o,
  output logic              frame_no,
  output logic              valid_no,
  output logic              err_o
);
  import pst_pkg::*;

  // ADDR_W >= 2 and PAD_CYC >= 1 assumed
  localparam int SPAN = (ADDR_W > PAD_CYC) ? ADDR_W : PAD_CYC;
  localparam int CW   = $clog2(SPAN + 1);

  tx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] hdr_q;
  logic              quiet_done, accept, start;
  logic              buf_full, take, have, pay_bit, pay_last, advance;
  logic [BYTE_W-1:0] buf_data;

  assign req_ready_o = (state_q == ST_IDLE) && quiet_done;
  assign accept      = req_valid_i && req_ready_o;
  assign start       = accept && (req_len_i != '0);
  assign advance     = (state_q == ST_PAY) && !gap_i;

  pst_quiet #(.QUIET_CYC(QUIET_CYC)) u_quiet (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_o(quiet_done)
  );

  pst_byte_feed #(.LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_feed (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .len_i       (req_len_i),
    .take_i      (take),
    .byte_valid_i(byte_valid_i),
    .byte_data_i (byte_data_i),
    .byte_ready_o(byte_ready_o),
    .full_o      (buf_full),
    .data_o      (buf_data)
  );

  pst_pay_shift #(.LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .len_i     (req_len_i),
    .advance_i (advance),
    .buf_full_i(buf_full),
    .buf_data_i(buf_data),
    .take_o    (take),
    .have_o    (have),
    .bit_o     (pay_bit),
    .last_o    (pay_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      hdr_q    <= '0;
      ser_o    <= 1'b0;
      frame_no <= 1'b1;
      valid_no <= 1'b1;
      err_o    <= 1'b0;
    end else begin
      err_o <= accept && (req_len_i == '0);
      // default slot: frame held low, data invalid
      ser_o    <= 1'b0;
      frame_no <= 1'b0;
      valid_no <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          frame_no <= 1'b1;
          if (start) begin
            ser_o    <= req_addr_i[0];
            frame_no <= 1'b0;
            hdr_q    <= req_addr_i >> 1;
            cnt_q    <= CW'(ADDR_W - 1);
            state_q  <= ST_HDR;
          end
        end
        ST_HDR: begin
          ser_o <= hdr_q[0];
          hdr_q <= hdr_q >> 1;
          if (cnt_q == CW'(1)) begin
            cnt_q   <= CW'(PAD_CYC);
            state_q <= ST_PAD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_PAD: begin
          if (cnt_q == CW'(1)) state_q <= ST_PAY;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_PAY: begin
          if (advance && have) begin
            ser_o    <= pay_bit;
            valid_no <= 1'b0;
            frame_no <= pay_last;
            if (pay_last) state_q <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          frame_no <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pst_tx_chk.sv
module pst_tx_chk #(
  parameter int QUIET_CYC = 15,
  localparam int QW = $clog2(QUIET_CYC + 1)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic byte_ready_o,
  input logic frame_no,
  input logic valid_no,
  input logic err_o
);
  logic [QW-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= '0;
    else if (since_q != QW'(QUIET_CYC)) since_q <= since_q + 1'b1;
  end

  assert_quiet_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q < QW'(QUIET_CYC)) |-> (!req_ready_o && frame_no));

  assert_hdr_invalid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_no) |-> valid_no);

  assert_last_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_no) |-> !valid_no);

  assert_tail_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_no && !valid_no) |=> (frame_no && valid_no && req_ready_o));

  assert_busy_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_no |-> !req_ready_o);

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_err_noframe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> frame_no);

  assert_feed_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_no && valid_no && req_ready_o) |-> !byte_ready_o);
endmodule

bind pkt_ser_tx pst_tx_chk #(.QUIET_CYC(QUIET_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .byte_ready_o(byte_ready_o),
  .frame_no    (frame_no),
  .valid_no    (valid_no),
  .err_o       (err_o)
);

// File: tb/sim_pkt_ser_tx.sv
module sim_pkt_ser_tx;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int LEN_W      = 8;
  localparam int BYTE_W     = 8;
  localparam int PAD_CYC    = 2;
  localparam int QUIET_CYC  = 15;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [LEN_W-1:0]  req_len_i = '0;
  logic byte_valid_i = 1'b0, byte_ready_o;
  logic [BYTE_W-1:0] byte_data_i = '0;
  logic gap_i = 1'b0;
  logic ser_o, frame_no, valid_no, err_o;

  pkt_ser_tx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTE_W(BYTE_W),
               .PAD_CYC(PAD_CYC), .QUIET_CYC(QUIET_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i),
    .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
    .byte_data_i(byte_data_i), .gap_i(gap_i),
    .ser_o(ser_o), .frame_no(frame_no), .valid_no(valid_no), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;
  int cyc = 0, mode = 0, pkt_id = 0;
  int cur_addr = 0, cur_len = 0, feed_idx = 0;
  bit pend_take = 0, in_pkt = 0, exp_idle = 0, pkt_done = 0;
  bit prev_f = 1, gap_prev = 0;
  int pos = 0, bitcnt = 0, nbytes = 0, under_cnt = 0, total_under = 0, last_slots = 0;
  logic [ADDR_W-1:0] hdr;
  logic [7:0] curbyte;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int p, input int k);
    return 8'(p * 37 + k * 91 + 5);
  endfunction

  task automatic cycle();
    bit f, v, s;
    @(negedge clk);
    cyc++;
    if (pend_take) feed_idx++;
    gap_prev = gap_i;
    f = frame_no; v = valid_no; s = ser_o;
    if (!in_pkt && prev_f && !f) begin
      in_pkt = 1; pos = 0; hdr = '0; bitcnt = 0; nbytes = 0;
    end
    if (in_pkt) begin
      if (pos < ADDR_W) begin
        hdr[pos] = s;
        if (pos == 0) chk(v == 1'b1, "R2 header slot valid_n", int'(v), 1);
        if (pos == ADDR_W - 1) chk(hdr == cur_addr[ADDR_W-1:0], "R2 address LSB first", int'(hdr), cur_addr);
      end else if (pos < ADDR_W + PAD_CYC) begin
        chk(!f && v, "R3 pad slot frame/valid", int'({f, v}), 1);
      end else begin
        if (gap_prev) chk(v && !f, "R5 gap slot idle", int'({f, v}), 1);
        if (!v) begin
          curbyte[bitcnt % 8] = s;
          bitcnt++;
          if (bitcnt % 8 == 0) begin
            chk(curbyte == byte_of(pkt_id, nbytes), "R4 payload byte", int'(curbyte), int'(byte_of(pkt_id, nbytes)));
            nbytes++;
          end
        end else if (!gap_prev) begin
          under_cnt++;
        end
      end
      if (f) begin
        chk(!v, "R7 last bit valid_n", int'(v), 0);
        chk(bitcnt == cur_len * 8, "R7 last bit position", bitcnt, cur_len * 8);
        in_pkt = 0; exp_idle = 1; last_slots = pos + 1;
      end
      pos++;
    end else if (exp_idle) begin
      chk(f && v, "R8 idle slot after frame", int'({f, v}), 3);
      chk(req_ready_o == 1'b1, "R8 ready in idle slot", int'(req_ready_o), 1);
      exp_idle = 0; pkt_done = 1;
    end
    prev_f = f;
    gap_i = (mode == 1) && (cyc % 5 == 3);
    byte_valid_i = (feed_idx < cur_len) && (mode != 2 || (cyc % 16) < 2);
    byte_data_i = byte_of(pkt_id, feed_idx);
    pend_take = byte_valid_i && byte_ready_o;
  endtask

  task automatic send_pkt(input int a, input int l);
    int t;
    t = 0;
    while (!req_ready_o && t < 200) begin cycle(); t++; end
    pkt_id++; cur_addr = a; cur_len = l; feed_idx = 0; under_cnt = 0; pkt_done = 0;
    byte_valid_i = 1'b0; pend_take = 0;
    req_valid_i = 1'b1; req_addr_i = ADDR_W'(a); req_len_i = LEN_W'(l);
    cycle();
    req_valid_i = 1'b0;
    t = 0;
    while (!pkt_done && t < 600) begin cycle(); t++; end
    chk(pkt_done, "R8 packet completed", int'(pkt_done), 1);
    chk(feed_idx == l, "R10 bytes taken per packet", feed_idx, l);
    chk(byte_ready_o == 1'b0, "R10 byte_ready low when idle", int'(byte_ready_o), 0);
    if (mode == 0) begin
      chk(under_cnt == 0, "R6 no idle slots with steady feed", under_cnt, 0);
      chk(last_slots == ADDR_W + PAD_CYC + 8 * l, "R4 packet slot count", last_slots, ADDR_W + PAD_CYC + 8 * l);
    end
    total_under += under_cnt;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(frame_no == 1'b1 && valid_no == 1'b1, "R1 reset line idle", int'({frame_no, valid_no}), 3);
    chk(req_ready_o == 1'b0, "R1 reset ready low", int'(req_ready_o), 0);
    chk(err_o == 1'b0, "R1 reset err low", int'(err_o), 0);
    rst_ni = 1'b1;
    // hold a request through the quiet window
    req_valid_i = 1'b1; req_addr_i = '0; req_len_i = LEN_W'(1);
    for (int k = 1; k <= QUIET_CYC; k++) begin
      cycle();
      if (k < QUIET_CYC) chk(!req_ready_o && frame_no, "R1 quiet window hold", int'({req_ready_o, frame_no}), 1);
      else chk(req_ready_o == 1'b1, "R1 ready after quiet window", int'(req_ready_o), 1);
    end
    req_valid_i = 1'b0;
    cycle();
    chk(frame_no == 1'b1, "R1 no frame without request", int'(frame_no), 1);

    // zero length reject
    req_valid_i = 1'b1; req_len_i = '0; req_addr_i = ADDR_W'(5);
    cycle();
    req_valid_i = 1'b0;
    chk(err_o == 1'b1, "R9 err pulse on zero length", int'(err_o), 1);
    chk(frame_no == 1'b1, "R9 no frame on zero length", int'(frame_no), 1);
    chk(req_ready_o == 1'b1, "R9 ready stays high", int'(req_ready_o), 1);
    cycle();
    chk(err_o == 1'b0, "R9 err pulse one cycle", int'(err_o), 0);
    chk(frame_no == 1'b1, "R9 line stays idle", int'(frame_no), 1);

    for (int m = 0; m < 3; m++) begin
      mode = m;
      for (int a = 0; a < (1 << ADDR_W); a++)
        for (int l = 1; l <= 3; l++)
          send_pkt(a, l);
    end
    chk(total_under > 0, "R6 idle slots under throttled feed", total_under, 1);

    // zero length right after a packet
    mode = 0;
    req_valid_i = 1'b1; req_len_i = '0;
    cycle();
    req_valid_i = 1'b0;
    chk(err_o == 1'b1, "R9 err after back-to-back packet", int'(err_o), 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule